// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of event timers and the interrupt fabric. Each timer channel reports a fire event and a clear event. The block turns these into activity on one of a set of interrupt lines. A per-timer route field picks the line. Per-timer options pick level or edge signalling, or message delivery. Level signalling sets a status bit and holds the line asserted until the event is cleared. Edge signalling gives a single-cycle pulse and leaves status clear. Message delivery raises a one-cycle request strobe and drives no line. Lines numbered at or above a threshold are active low, so an idle line of that kind rests high.

A global legacy replacement mode takes timer 0 onto line 0 and timer 1 onto line 8, whatever their route fields hold. In that mode the block also stops passing the external interval-timer and real-time-clock interrupt inputs through to those two lines, and it pulls the enable output of the interval timer low. The real-time-clock level is latched at all times. When legacy mode ends, line 8 therefore shows the current clock level at once. A global enable gates all timer activity.

All inputs are sampled on the rising clock edge. Every output is a function of registered state, so it shows the effect of an input one edge after that input is sampled.

Top module: `tir_router`

## Requirements
- R1: Outside legacy mode, a timer in level mode whose 5-bit route field holds r drives line r; a route value of NUM_LINES or more drives no line; a line is asserted while any source that targets it is active.
- R2: While legacy mode is set, timer 0 drives line 0 and timer 1 drives line 8, whatever their route fields hold; timers 2 and up keep their route fields.
- R3: A fire on an enabled timer in level mode (lvl bit 1, message bit 0) sets its status bit one edge later, and the status bit and its line stay asserted until cleared.
- R4: A fire on an enabled timer in edge mode (lvl bit 0) leaves its status bit 0 and asserts its line for exactly one cycle.
- R5: Lines numbered 16 and above are active low: asserted drives 0 and idle drives 1; lines below 16 are active high.
- R6: A clear, a low timer enable or a low global enable clears the timer's status bit and deasserts its line at the next edge; a clear in the same cycle as a fire wins.
- R7: With the message bit set, a fire on an enabled timer gives a one-cycle msg_req_o pulse, leaves status 0 and drives no line; setting the message bit deasserts any line the timer was holding.
- R8: Setting legacy mode drives pit_en_o low and stops the pass-through inputs reaching lines 0 and 8; clearing it restores pit_en_o high, and line 8 then follows the latched real-time-clock level.
- R9: Outside legacy mode, pit_in_i appears on line 0 and rtc_in_i on line 8 one edge after sampling; rtc_in_i is latched even during legacy mode.
- R10: A fire on a timer whose own enable or the global enable is low has no effect on status, lines or msg_req_o.
- R11: After reset all status and message outputs are 0, pit_en_o is 1, lines below 16 are 0, and lines 16 and above are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en_i | input | 1 | Global enable for timer interrupt activity |
| legacy_i | input | 1 | Legacy replacement mode |
| tmr_en_i | input | NUM_TMR | Per-timer interrupt enable |
| lvl_i | input | NUM_TMR | Per-timer signalling: 1 level, 0 edge |
| msg_en_i | input | NUM_TMR | Per-timer message delivery select |
| route_i | input | NUM_TMR*ROUTE_W | Per-timer route fields; timer t at bits t*ROUTE_W upward |
| fire_i | input | NUM_TMR | Per-timer fire event |
| clr_i | input | NUM_TMR | Per-timer clear event |
| pit_in_i | input | 1 | Interval-timer interrupt input |
| rtc_in_i | input | 1 | Real-time-clock interrupt level input |
| irq_o | output | NUM_LINES | Interrupt lines at their physical polarity |
| status_o | output | NUM_TMR | Level-mode status bits |
| msg_req_o | output | NUM_TMR | Message request strobes |
| pit_en_o | output | 1 | Enable for the external interval timer |

## Verification
The hardest state to reach is the exit from legacy mode while a stale real-time-clock level is held. Line 8 must then show a value that changed while that line was being driven by timer 1 and not by the input. The stimulus enters legacy mode with the clock input high, fires and clears timer 1 on line 8, and changes the clock input twice while legacy mode holds. It then leaves legacy mode and checks that line 8 shows the final latched level on the first cycle. A long pseudo-random phase also mixes legacy toggles, out-of-range routes and colliding routes, and a cycle-by-cycle model is compared on every clock.

// File: rtl/tir_pkg.sv
package tir_pkg;

   // Signalling kind selected by a timer's level bit
   typedef enum logic {
      SIG_EDGE  = 1'b0,
      SIG_LEVEL = 1'b1
   } tir_sig_e;

   // Registered snapshot of a channel's activity
   typedef struct packed {
      logic stat;
      logic pulse;
      logic msg;
   } tir_act_s;

   // Physical level of a line from its logical assertion
   function automatic logic tir_phys(input logic asserted, input logic low_act);
      return low_act ? ~asserted : asserted;
   endfunction

endpackage

// File: rtl/tir_chan.sv
module tir_chan
   import tir_pkg::*;
#(
   parameter int ROUTE_W  = 5,
   parameter int CHAN_IDX = 0,
   parameter int LEG_A    = 0,
   parameter int LEG_B    = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               glb_en,
   input  logic               leg_q,
   input  logic               tmr_en,
   input  logic               lvl,
   input  logic               msg_en,
   input  logic [ROUTE_W-1:0] route,
   input  logic               fire,
   input  logic               clr,
   output logic               drive,
   output logic [ROUTE_W-1:0] eff_route,
   output logic               stat_o,
   output logic               msg_o
);

   tir_act_s          act_q, act_d;
   logic [ROUTE_W-1:0] route_q;
   logic              en_ok;
   logic              kill;
   tir_sig_e          sig;

   assign sig   = tir_sig_e'(lvl);
   assign en_ok = glb_en & tmr_en;
   assign kill  = clr | ~en_ok | msg_en;

   always_comb begin
      act_d       = act_q;
      act_d.pulse = fire & ~kill & (sig == SIG_EDGE);
      act_d.msg   = fire & en_ok & msg_en & ~clr;
      if (kill)
         act_d.stat = 1'b0;
      else if (fire)
         act_d.stat = (sig == SIG_LEVEL);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q   <= '0;
         route_q <= '0;
      end else begin
         act_q   <= act_d;
         route_q <= route;
      end
   end

   // Legacy override applies only to the first two channels
   generate
      if (CHAN_IDX == 0) begin : g_leg_a
         assign eff_route = leg_q ? ROUTE_W'(LEG_A) : route_q;
      end else if (CHAN_IDX == 1) begin : g_leg_b
         assign eff_route = leg_q ? ROUTE_W'(LEG_B) : route_q;
      end else begin : g_plain
         assign eff_route = route_q;
      end
   endgenerate

   assign drive  = act_q.stat | act_q.pulse;
   assign stat_o = act_q.stat;
   assign msg_o  = act_q.msg;

endmodule

// File: rtl/tir_legacy.sv
module tir_legacy (
   input  logic clk,
   input  logic rst_n,
   input  logic legacy,
   input  logic pit_in,
   input  logic rtc_in,
   output logic leg_q,
   output logic pit_q,
   output logic rtc_q,
   output logic pit_en
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         leg_q <= 1'b0;
         pit_q <= 1'b0;
         rtc_q <= 1'b0;
      end else begin
         leg_q <= legacy;
         pit_q <= pit_in;
         rtc_q <= rtc_in;
      end
   end

   assign pit_en = ~leg_q;

endmodule

// File: rtl/tir_line_map.sv
module tir_line_map
   import tir_pkg::*;
#(
   parameter int NUM_TMR   = 3,
   parameter int NUM_LINES = 24,
   parameter int ROUTE_W   = 5,
   parameter int LOW_FROM  = 16,
   parameter int LEG_A     = 0,
   parameter int LEG_B     = 8
) (
   input  logic [NUM_TMR-1:0]         drive,
   input  logic [NUM_TMR*ROUTE_W-1:0] eff_route,
   input  logic                       leg_q,
   input  logic                       pit_q,
   input  logic                       rtc_q,
   output logic [NUM_LINES-1:0]       lines
);

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic hit;
      logic pass;

      always_comb begin
         hit = 1'b0;
         for (int t = 0; t < NUM_TMR; t++) begin
            if (drive[t] && eff_route[t*ROUTE_W +: ROUTE_W] == ROUTE_W'(l))
               hit = 1'b1;
         end
      end

      if (l == LEG_A) begin : g_pit
         assign pass = ~leg_q & pit_q;
      end else if (l == LEG_B) begin : g_rtc
         assign pass = ~leg_q & rtc_q;
      end else begin : g_none
         assign pass = 1'b0;
      end

      if (l >= LOW_FROM) begin : g_low
         assign lines[l] = tir_phys(hit | pass, 1'b1);
      end else begin : g_high
         assign lines[l] = tir_phys(hit | pass, 1'b0);
      end
   end

endmodule

// File: rtl/tir_router.sv
module tir_router #(
   parameter int NUM_TMR   = 3,
   parameter int NUM_LINES = 24,
   parameter int ROUTE_W   = 5,
   parameter int LOW_FROM  = 16,
   parameter int LEG_A     = 0,
   parameter int LEG_B     = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       glb_en_i,
   input  logic                       legacy_i,
   input  logic [NUM_TMR-1:0]         tmr_en_i,
   input  logic [NUM_TMR-1:0]         lvl_i,
   input  logic [NUM_TMR-1:0]         msg_en_i,
   input  logic [NUM_TMR*ROUTE_W-1:0] route_i,
   input  logic [NUM_TMR-1:0]         fire_i,
   input  logic [NUM_TMR-1:0]         clr_i,
   input  logic                       pit_in_i,
   input  logic                       rtc_in_i,
   output logic [NUM_LINES-1:0]       irq_o,
   output logic [NUM_TMR-1:0]         status_o,
   output logic [NUM_TMR-1:0]         msg_req_o,
   output logic                       pit_en_o
);

   localparam int ROUTE_SPAN = 1 << ROUTE_W;

   // Elaboration-time parameter checks
   if (NUM_TMR < 2) begin : g_bad_tmr
      $error("tir_router: NUM_TMR must be at least 2");
   end
   if (LEG_A >= NUM_LINES || LEG_B >= NUM_LINES || LEG_A == LEG_B) begin : g_bad_leg
      $error("tir_router: legacy lines must be distinct and inside NUM_LINES");
   end
   if (LEG_A >= ROUTE_SPAN || LEG_B >= ROUTE_SPAN) begin : g_bad_rw
      $error("tir_router: ROUTE_W too narrow for legacy lines");
   end
   if (LOW_FROM > NUM_LINES) begin : g_bad_low
      $error("tir_router: LOW_FROM beyond NUM_LINES");
   end

   logic                       leg_q, pit_q, rtc_q;
   logic [NUM_TMR-1:0]         drive;
   logic [NUM_TMR*ROUTE_W-1:0] eff_route;

   tir_legacy u_leg (
      .clk    (clk),
      .rst_n  (rst_n),
      .legacy (legacy_i),
      .pit_in (pit_in_i),
      .rtc_in (rtc_in_i),
      .leg_q  (leg_q),
      .pit_q  (pit_q),
      .rtc_q  (rtc_q),
      .pit_en (pit_en_o)
   );

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_chan
      tir_chan #(
         .ROUTE_W  (ROUTE_W),
         .CHAN_IDX (t),
         .LEG_A    (LEG_A),
         .LEG_B    (LEG_B)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .glb_en    (glb_en_i),
         .leg_q     (leg_q),
         .tmr_en    (tmr_en_i[t]),
         .lvl       (lvl_i[t]),
         .msg_en    (msg_en_i[t]),
         .route     (route_i[t*ROUTE_W +: ROUTE_W]),
         .fire      (fire_i[t]),
         .clr       (clr_i[t]),
         .drive     (drive[t]),
         .eff_route (eff_route[t*ROUTE_W +: ROUTE_W]),
         .stat_o    (status_o[t]),
         .msg_o     (msg_req_o[t])
      );
   end

   tir_line_map #(
      .NUM_TMR   (NUM_TMR),
      .NUM_LINES (NUM_LINES),
      .ROUTE_W   (ROUTE_W),
      .LOW_FROM  (LOW_FROM),
      .LEG_A     (LEG_A),
      .LEG_B     (LEG_B)
   ) u_map (
      .drive     (drive),
      .eff_route (eff_route),
      .leg_q     (leg_q),
      .pit_q     (pit_q),
      .rtc_q     (rtc_q),
      .lines     (irq_o)
   );

endmodule

// File: rtl/tir_router_chk.sv
module tir_router_chk #(
   parameter int NUM_TMR = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               glb_en_i,
   input logic               legacy_i,
   input logic [NUM_TMR-1:0] tmr_en_i,
   input logic [NUM_TMR-1:0] lvl_i,
   input logic [NUM_TMR-1:0] msg_en_i,
   input logic [NUM_TMR-1:0] fire_i,
   input logic [NUM_TMR-1:0] clr_i,
   input logic [NUM_TMR-1:0] status_o,
   input logic [NUM_TMR-1:0] msg_req_o,
   input logic               pit_en_o
);

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_t
      a_r3_level_set: assert property (@(posedge clk) disable iff (!rst_n)
         (fire_i[t] && lvl_i[t] && tmr_en_i[t] && glb_en_i && !clr_i[t] && !msg_en_i[t])
         |=> status_o[t]);

      a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[t] || !tmr_en_i[t]) |=> !status_o[t]);

      a_r7_msg_excl: assert property (@(posedge clk) disable iff (!rst_n)
         msg_req_o[t] |-> !status_o[t]);

      a_r7_msg_cause: assert property (@(posedge clk) disable iff (!rst_n)
         msg_req_o[t] |-> $past(fire_i[t]));
   end

   a_r10_global_off: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en_i |=> (status_o == '0 && msg_req_o == '0));

   a_r8_pit_off: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_i |=> !pit_en_o);

   a_r8_pit_on: assert property (@(posedge clk) disable iff (!rst_n)
      !legacy_i |=> pit_en_o);

endmodule

bind tir_router tir_router_chk #(.NUM_TMR(NUM_TMR)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .glb_en_i  (glb_en_i),
   .legacy_i  (legacy_i),
   .tmr_en_i  (tmr_en_i),
   .lvl_i     (lvl_i),
   .msg_en_i  (msg_en_i),
   .fire_i    (fire_i),
   .clr_i     (clr_i),
   .status_o  (status_o),
   .msg_req_o (msg_req_o),
   .pit_en_o  (pit_en_o)
);

// File: tb/sim_tir_router.sv
module sim_tir_router;

   localparam int CLK_PERIOD = 10;
   localparam int NT = 3;
   localparam int NL = 24;
   localparam int RW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic glb_en_i = 1'b0, legacy_i = 1'b0, pit_in_i = 1'b0, rtc_in_i = 1'b0;
   logic [NT-1:0] tmr_en_i = '0, lvl_i = '0, msg_en_i = '0, fire_i = '0, clr_i = '0;
   logic [NT*RW-1:0] route_i = '0;
   logic [NL-1:0] irq_o;
   logic [NT-1:0] status_o, msg_req_o;
   logic pit_en_o;

   int checks = 0;
   int failures = 0;
   string tag = "R11";

   always #(CLK_PERIOD/2) clk = ~clk;

   tir_router u0 (
      .clk(clk), .rst_n(rst_n), .glb_en_i(glb_en_i), .legacy_i(legacy_i),
      .tmr_en_i(tmr_en_i), .lvl_i(lvl_i), .msg_en_i(msg_en_i), .route_i(route_i),
      .fire_i(fire_i), .clr_i(clr_i), .pit_in_i(pit_in_i), .rtc_in_i(rtc_in_i),
      .irq_o(irq_o), .status_o(status_o), .msg_req_o(msg_req_o), .pit_en_o(pit_en_o)
   );

   // Behavioural reference state
   bit m_stat[NT], m_pulse[NT], m_msg[NT];
   int m_route[NT];
   bit m_leg, m_pit, m_rtc;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int t = 0; t < NT; t++) begin
            m_stat[t] = 0; m_pulse[t] = 0; m_msg[t] = 0; m_route[t] = 0;
         end
         m_leg = 0; m_pit = 0; m_rtc = 0;
      end else begin
         for (int t = 0; t < NT; t++) begin
            bit ok, gone;
            ok   = glb_en_i && tmr_en_i[t];
            gone = clr_i[t] || !ok || msg_en_i[t];
            m_pulse[t] = fire_i[t] && !gone && !lvl_i[t];
            m_msg[t]   = fire_i[t] && ok && msg_en_i[t] && !clr_i[t];
            if (gone) m_stat[t] = 0;
            else if (fire_i[t]) m_stat[t] = lvl_i[t];
            m_route[t] = int'(route_i[t*RW +: RW]);
         end
         m_leg = legacy_i; m_pit = pit_in_i; m_rtc = rtc_in_i;
      end
   end

   function automatic logic [NL-1:0] exp_lines();
      logic [NL-1:0] v = '0;
      for (int t = 0; t < NT; t++) begin
         int r = m_route[t];
         if (m_leg && t == 0) r = 0;
         if (m_leg && t == 1) r = 8;
         if ((m_stat[t] || m_pulse[t]) && r < NL) v[r] = 1'b1;
      end
      if (!m_leg) begin
         v[0] = v[0] | m_pit;
         v[8] = v[8] | m_rtc;
      end
      for (int l = 16; l < NL; l++) v[l] = ~v[l];
      return v;
   endfunction

   function automatic logic [NT-1:0] pack(input bit a[NT]);
      logic [NT-1:0] v;
      for (int t = 0; t < NT; t++) v[t] = a[t];
      return v;
   endfunction

   // Per-clock comparison against the model
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         checks++;
         if (irq_o !== exp_lines() || status_o !== pack(m_stat) ||
             msg_req_o !== pack(m_msg) || pit_en_o !== !m_leg) begin
            failures++;
            $display("FAIL %s model: irq=%h/%h stat=%b/%b msg=%b/%b pit_en=%b/%b",
                     tag, irq_o, exp_lines(), status_o, pack(m_stat),
                     msg_req_o, pack(m_msg), pit_en_o, !m_leg);
         end
      end
   end

   task automatic chk(input string rq, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic fire(input int t);
      fire_i[t] = 1'b1; step(); fire_i[t] = 1'b0;
   endtask

   task automatic clear(input int t);
      clr_i[t] = 1'b1; step(); clr_i[t] = 1'b0;
   endtask

   task automatic set_route(input int t, input int r);
      route_i[t*RW +: RW] = RW'(r);
   endtask

   // Watchdog
   initial begin
      #(CLK_PERIOD*50000);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      step(3);
      rst_n = 1'b1;
      step();
      tag = "R11";
      chk("R11", "reset lines", 32'(irq_o), 32'(24'hFF0000));
      chk("R11", "reset status", 32'(status_o), 0);
      chk("R11", "reset pit_en", 32'(pit_en_o), 1);

      glb_en_i = 1; tmr_en_i = '1; lvl_i = '1;
      tag = "R1"; set_route(0, 5); set_route(2, 12); step();
      fire(0);
      chk("R3", "status after level fire", 32'(status_o[0]), 1);
      chk("R1", "line 5", 32'(irq_o[5]), 1);
      step(3);
      chk("R3", "line 5 held", 32'(irq_o[5]), 1);
      set_route(1, 5); fire(1);
      clear(0);
      chk("R1", "shared line still on", 32'(irq_o[5]), 1);
      clear(1);
      chk("R6", "shared line off", 32'(irq_o[5]), 0);
      set_route(0, 30); step(); fire(0);
      chk("R1", "out-of-range route", 32'(irq_o), 32'(24'hFF0000));
      clear(0);

      tag = "R5"; set_route(1, 20); step(); fire(1);
      chk("R5", "line 20 active low", 32'(irq_o[20]), 0);
      clear(1);
      chk("R5", "line 20 idle high", 32'(irq_o[20]), 1);

      tag = "R4"; lvl_i[2] = 0; set_route(2, 3); step(); fire(2);
      chk("R4", "edge pulse", 32'(irq_o[3]), 1);
      chk("R4", "edge status", 32'(status_o[2]), 0);
      step();
      chk("R4", "pulse ends", 32'(irq_o[3]), 0);
      lvl_i[2] = 1;

      tag = "R6"; set_route(0, 6); step(); fire(0);
      tmr_en_i[0] = 0; step();
      chk("R6", "timer disable", 32'(irq_o[6]), 0);
      tmr_en_i[0] = 1; fire(0);
      glb_en_i = 0; step();
      chk("R6", "global disable", 32'(status_o[0]), 0);
      glb_en_i = 1;
      fire_i[0] = 1; clr_i[0] = 1; step(); fire_i[0] = 0; clr_i[0] = 0;
      chk("R6", "clear beats fire", 32'(status_o[0]), 0);

      tag = "R10"; tmr_en_i[1] = 0; fire(1);
      chk("R10", "disabled timer fire", 32'(status_o[1]), 0);
      tmr_en_i[1] = 1; glb_en_i = 0; fire(1);
      chk("R10", "global off fire", 32'(irq_o[20]), 1);
      glb_en_i = 1;

      tag = "R7"; fire(0);
      msg_en_i[0] = 1; step();
      chk("R7", "msg enable drops line", 32'(irq_o[6]), 0);
      fire(0);
      chk("R7", "msg strobe", 32'(msg_req_o[0]), 1);
      chk("R7", "msg no line", 32'(irq_o[6]), 0);
      step();
      chk("R7", "msg strobe one cycle", 32'(msg_req_o[0]), 0);
      msg_en_i[0] = 0;

      tag = "R9"; pit_in_i = 1; rtc_in_i = 1; step();
      chk("R9", "pit pass", 32'(irq_o[0]), 1);
      chk("R9", "rtc pass", 32'(irq_o[8]), 1);

      tag = "R8"; legacy_i = 1; step();
      chk("R8", "pit_en low", 32'(pit_en_o), 0);
      chk("R8", "line 0 gated", 32'(irq_o[0]), 0);
      chk("R8", "line 8 gated", 32'(irq_o[8]), 0);
      tag = "R2"; fire(0);
      chk("R2", "timer 0 on line 0", 32'(irq_o[0]), 1);
      chk("R2", "timer 0 off line 6", 32'(irq_o[6]), 0);
      clear(0); fire(1);
      chk("R2", "timer 1 on line 8", 32'(irq_o[8]), 1);
      rtc_in_i = 0; step(); rtc_in_i = 1;
      clear(1);
      tag = "R8"; legacy_i = 0; step();
      chk("R8", "pit_en restored", 32'(pit_en_o), 1);
      chk("R8", "line 8 latched rtc", 32'(irq_o[8]), 1);
      pit_in_i = 0; rtc_in_i = 0;

      tag = "R1"; lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         fire_i   = lfsr[2:0];
         clr_i    = (lfsr[7:5] == 3'b111) ? lfsr[10:8] : '0;
         lvl_i    = lfsr[13:11];
         msg_en_i = (lfsr[15:14] == 2'b11) ? 3'b001 : '0;
         legacy_i = (i % 97) > 60;
         pit_in_i = lfsr[4];
         rtc_in_i = lfsr[9];
         glb_en_i = (i % 53) != 0;
         tmr_en_i = (lfsr[6:3] == 4'h0) ? 3'b011 : 3'b111;
         if (i % 17 == 0) set_route(i % NT, int'(lfsr[12:8]));
         step();
      end
      fire_i = '0; clr_i = '0;
      step(2);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule